// File: doc/BRIEF.md
# Memory-Resident Register Workspace Controller

This block handles the register file of a 16-bit processor whose general registers live in ordinary memory instead of flip-flops. Only three values are kept inside: the program counter, the status word and a workspace pointer. The sixteen general registers form a 16-word window in memory that starts at the workspace pointer. The window can slide anywhere in the 16-bit address space. Each register access becomes a single word access on a synchronous memory port that is addressed in bytes.

The controller takes one command at a time. There are four commands: read a register, write a register, switch context through a vector, and return from a context. The switch fetches a new pointer and program counter from two vector words. It then stores the old pointer, program counter and status in the top three registers of the new window. Each window therefore links back to the one before it, forming a chain without a stack. A return follows that link and restores all three values. `busy` is high while a command runs, and `done` marks its final cycle.

Top module: `regwin_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter, status and workspace pointer to zero and holds `busy` and `done` low.
- R2: Register n is at byte address (WP + 2*n) mod 2^16. Every address driven on the memory port has bit 0 equal to zero.
- R3: A register write (`cmd_op` = 1) issues exactly one write of `cmd_wdata` to register `cmd_reg`. It keeps `busy` high for 2 cycles and leaves PC, status and WP unchanged.
- R4: A register read (`cmd_op` = 0) issues exactly one read. It presents the word on `rd_data` when `done` is high, keeps `busy` high for 3 cycles and leaves PC, status and WP unchanged.
- R5: A context switch (`cmd_op` = 2) reads the word at the vector address as the new WP and the word at vector+2 as the new PC. Status is unchanged.
- R6: A context switch then writes the old WP to byte offset 26 (R13), the old PC to offset 28 (R14) and the old status to offset 30 (R15) of the new window.
- R7: A context switch issues both vector reads before any save write, so a vector that lies inside the new window still gives the correct WP and PC.
- R8: A return (`cmd_op` = 3) reads R13, R14 and R15 of the current window and loads them into WP, PC and status. It issues no writes.
- R9: Nested context switches followed by the same number of returns restore the contexts in reverse order.
- R10: A context switch keeps `busy` high for 6 cycles and a return for 5. `done` is high only in the last busy cycle.
- R11: A command presented while `busy` is high is ignored and causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 0 read reg, 1 write reg, 2 switch, 3 return |
| cmd_reg | input | 4 | Register index for read or write |
| cmd_wdata | input | 16 | Data for a register write |
| cmd_vec | input | 16 | Vector byte address for a switch |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final cycle of a command |
| rd_data | output | 16 | Word from the last register read |
| pc_o | output | 16 | Program counter |
| st_o | output | 16 | Status |
| wp_o | output | 16 | Workspace pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address, bit 0 zero |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the request |

## Verification
The bench places a switch vector inside the new window so that the second vector word is the slot R13 later overwrites. A design that saved before it finished reading would load the old pointer as the new PC. A window near the top of memory checks that the save addresses wrap to the bottom instead of being cut off or saturated. A chain of two switches followed by two returns must restore each context in reverse order. A broken link would leave the machine in the wrong window. A write command sent in the middle of a return must produce no extra access, and the bench counts reads, writes and busy cycles to catch a sequencer that runs too long or too short.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int WORD_W         = 16;
    localparam int REG_CNT        = 16;
    localparam int IDX_W          = $clog2(REG_CNT);
    localparam int BYTES_PER_WORD = 2;
    localparam int LINK_ST        = REG_CNT - 1;
    localparam int LINK_PC        = REG_CNT - 2;
    localparam int LINK_WP        = REG_CNT - 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef enum logic [1:0] {
        OP_RDREG  = 2'd0,
        OP_WRREG  = 2'd1,
        OP_SWITCH = 2'd2,
        OP_RETURN = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BASE_WP,
        BASE_VEC,
        BASE_NEW
    } base_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_CAP,
        S_WR,
        S_SW_V0,
        S_SW_V1,
        S_SW_S13,
        S_SW_S14,
        S_SW_S15,
        S_RT_13,
        S_RT_14,
        S_RT_15,
        S_RT_CAP,
        S_DONE
    } seq_e;

    typedef struct packed {
        word_t wp;
        word_t pc;
        word_t st;
    } ctx_t;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t wdata;
    } mreq_t;

    // Byte address of slot idx in a window at base, wrapped and word aligned.
    function automatic word_t slot_addr(word_t base, ridx_t idx);
        word_t off;
        off = word_t'(BYTES_PER_WORD) * word_t'(idx);
        return (base + off) & ~word_t'(1);
    endfunction

endpackage

// File: rtl/regwin_ctx.sv
module regwin_ctx
    import regwin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  ctx_t ctx_next,
    output ctx_t ctx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (commit) begin
            ctx <= ctx_next;
        end
    end

endmodule

// File: rtl/regwin_agen.sv
module regwin_agen
    import regwin_pkg::*;
(
    input  base_e base_sel,
    input  word_t wp,
    input  word_t vec,
    input  word_t new_wp,
    input  ridx_t idx,
    output word_t addr
);

    word_t base;

    always_comb begin
        unique case (base_sel)
            BASE_VEC: base = vec;
            BASE_NEW: base = new_wp;
            default:  base = wp;
        endcase
        addr = slot_addr(base, idx);
    end

endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
    import regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  ridx_t      cmd_reg,
    input  word_t      cmd_wdata,
    input  word_t      cmd_vec,
    input  ctx_t       ctx,
    input  word_t      mem_rdata,
    output mreq_t      mreq,
    output base_e      base_sel,
    output ridx_t      idx,
    output word_t      vec_q,
    output word_t      new_wp,
    output logic       commit,
    output ctx_t       ctx_next,
    output word_t      rd_data,
    output logic       busy,
    output logic       done
);

    seq_e  state, nxt;
    ridx_t reg_q;
    word_t wdata_q;
    word_t tmp_pc;
    word_t rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            reg_q   <= '0;
            wdata_q <= '0;
            vec_q   <= '0;
            new_wp  <= '0;
            tmp_pc  <= '0;
            rd_q    <= '0;
        end else begin
            state <= nxt;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        reg_q   <= cmd_reg;
                        wdata_q <= cmd_wdata;
                        vec_q   <= cmd_vec;
                    end
                end
                S_SW_V1:  new_wp <= mem_rdata;
                S_SW_S13: tmp_pc <= mem_rdata;
                S_RT_14:  new_wp <= mem_rdata;
                S_RT_15:  tmp_pc <= mem_rdata;
                S_RD_CAP: rd_q   <= mem_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        nxt      = state;
        mreq     = '0;
        base_sel = BASE_WP;
        idx      = '0;
        commit   = 1'b0;
        ctx_next = ctx;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_e'(cmd_op))
                        OP_RDREG:  nxt = S_RD_ISSUE;
                        OP_WRREG:  nxt = S_WR;
                        OP_SWITCH: nxt = S_SW_V0;
                        default:   nxt = S_RT_13;
                    endcase
                end
            end
            S_RD_ISSUE: begin
                mreq.req = 1'b1;
                idx      = reg_q;
                nxt      = S_RD_CAP;
            end
            S_RD_CAP: nxt = S_DONE;
            S_WR: begin
                mreq.req   = 1'b1;
                mreq.we    = 1'b1;
                mreq.wdata = wdata_q;
                idx        = reg_q;
                nxt        = S_DONE;
            end
            S_SW_V0: begin
                mreq.req = 1'b1;
                base_sel = BASE_VEC;
                idx      = ridx_t'(0);
                nxt      = S_SW_V1;
            end
            S_SW_V1: begin
                mreq.req = 1'b1;
                base_sel = BASE_VEC;
                idx      = ridx_t'(1);
                nxt      = S_SW_S13;
            end
            S_SW_S13: begin
                mreq.req   = 1'b1;
                mreq.we    = 1'b1;
                mreq.wdata = ctx.wp;
                base_sel   = BASE_NEW;
                idx        = ridx_t'(LINK_WP);
                nxt        = S_SW_S14;
            end
            S_SW_S14: begin
                mreq.req   = 1'b1;
                mreq.we    = 1'b1;
                mreq.wdata = ctx.pc;
                base_sel   = BASE_NEW;
                idx        = ridx_t'(LINK_PC);
                nxt        = S_SW_S15;
            end
            S_SW_S15: begin
                mreq.req    = 1'b1;
                mreq.we     = 1'b1;
                mreq.wdata  = ctx.st;
                base_sel    = BASE_NEW;
                idx         = ridx_t'(LINK_ST);
                commit      = 1'b1;
                ctx_next.wp = new_wp;
                ctx_next.pc = tmp_pc;
                nxt         = S_DONE;
            end
            S_RT_13: begin
                mreq.req = 1'b1;
                idx      = ridx_t'(LINK_WP);
                nxt      = S_RT_14;
            end
            S_RT_14: begin
                mreq.req = 1'b1;
                idx      = ridx_t'(LINK_PC);
                nxt      = S_RT_15;
            end
            S_RT_15: begin
                mreq.req = 1'b1;
                idx      = ridx_t'(LINK_ST);
                nxt      = S_RT_CAP;
            end
            S_RT_CAP: begin
                commit      = 1'b1;
                ctx_next.wp = new_wp;
                ctx_next.pc = tmp_pc;
                ctx_next.st = mem_rdata;
                nxt         = S_DONE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    assign rd_data = rd_q;
    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);

endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [3:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic [15:0] cmd_vec,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic [15:0] pc_o,
    output logic [15:0] st_o,
    output logic [15:0] wp_o,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);

    ctx_t  ctx, ctx_next;
    logic  commit;
    mreq_t mreq;
    base_e base_sel;
    ridx_t idx;
    word_t vec_q, new_wp, addr;

    regwin_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .ctx_next (ctx_next),
        .ctx      (ctx)
    );

    regwin_agen u_agen (
        .base_sel (base_sel),
        .wp       (ctx.wp),
        .vec      (vec_q),
        .new_wp   (new_wp),
        .idx      (idx),
        .addr     (addr)
    );

    regwin_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_reg   (ridx_t'(cmd_reg)),
        .cmd_wdata (cmd_wdata),
        .cmd_vec   (cmd_vec),
        .ctx       (ctx),
        .mem_rdata (mem_rdata),
        .mreq      (mreq),
        .base_sel  (base_sel),
        .idx       (idx),
        .vec_q     (vec_q),
        .new_wp    (new_wp),
        .commit    (commit),
        .ctx_next  (ctx_next),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done)
    );

    assign pc_o      = ctx.pc;
    assign st_o      = ctx.st;
    assign wp_o      = ctx.wp;
    assign mem_req   = mreq.req;
    assign mem_we    = mreq.we;
    assign mem_addr  = addr;
    assign mem_wdata = mreq.wdata;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
    import regwin_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] pc_o,
    input logic [15:0] st_o,
    input logic [15:0] wp_o
);

    logic [1:0] op_q;
    logic       wr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (cmd_valid && !busy) begin
            op_q <= cmd_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            wr_seen <= 1'b0;
        end else if (mem_req && mem_we) begin
            wr_seen <= 1'b1;
        end
    end

    // R2
    even_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[0] == 1'b0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R3
    reg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (op_q == 2'(OP_RDREG) || op_q == 2'(OP_WRREG)))
            |-> ($stable(wp_o) && $stable(pc_o) && $stable(st_o)));

    // R7
    vec_order_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q == 2'(OP_SWITCH) && mem_req && !mem_we) |-> !wr_seen);

    // R8
    ret_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q == 2'(OP_RETURN)) |-> !(mem_req && mem_we));

endmodule

bind regwin_top regwin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .pc_o      (pc_o),
    .st_o      (st_o),
    .wp_o      (wp_o)
);

// File: tb/sim_regwin_top.sv
`timescale 1ns/1ps
module sim_regwin_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_vec = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] rd_data, pc_o, st_o, wp_o, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [0:1023];
    int n_rd = 0, n_wr = 0, n_busy = 0, n_odd = 0, n_order = 0;
    logic wr_seen = 1'b0;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    regwin_top u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_vec(cmd_vec),
        .busy(busy), .done(done), .rd_data(rd_data), .pc_o(pc_o),
        .st_o(st_o), .wp_o(wp_o), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int ix(input logic [15:0] a);
        return int'(a[10:1]);
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_addr[0]) n_odd++;
            if (mem_we) begin
                mem[ix(mem_addr)] <= mem_wdata;
                n_wr++;
            end else begin
                mem_rdata <= mem[ix(mem_addr)];
                n_rd++;
                if (wr_seen) n_order++;
            end
        end
        if (busy) n_busy++;
        if (!busy) wr_seen = 1'b0;
        else if (mem_req && mem_we) wr_seen = 1'b1;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int s_rd, s_wr, s_busy;

    task automatic run_cmd(input logic [1:0] op, input logic [3:0] r,
                           input logic [15:0] d, input logic [15:0] v);
        @(negedge clk);
        s_rd = n_rd; s_wr = n_wr; s_busy = n_busy;
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_wdata = d; cmd_vec = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ctx(input string tag, input logic [15:0] wp,
                           input logic [15:0] pc, input logic [15:0] st);
        chk({tag, " wp"}, wp_o, wp);
        chk({tag, " pc"}, pc_o, pc);
        chk({tag, " st"}, st_o, st);
    endtask

    task automatic chk_cnt(input string tag, input int rd, input int wr, input int cyc);
        chk({tag, " reads"}, 16'(n_rd - s_rd), 16'(rd));
        chk({tag, " writes"}, 16'(n_wr - s_wr), 16'(wr));
        chk({tag, " busy cycles"}, 16'(n_busy - s_busy), 16'(cyc));
    endtask

    task automatic t_reset();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_ctx("R1 reset", 16'h0000, 16'h0000, 16'h0000);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
    endtask

    task automatic t_regs();
        run_cmd(2'd1, 4'd5, 16'h1234, 16'h0);
        chk("R3 R2 write slot", mem[ix(16'h000A)], 16'h1234);
        chk_cnt("R3", 0, 1, 2);
        chk_ctx("R3 keep", 16'h0000, 16'h0000, 16'h0000);
        mem[ix(16'h0010)] = 16'hA5C3;
        run_cmd(2'd0, 4'd8, 16'h0, 16'h0);
        chk("R4 read data", rd_data, 16'hA5C3);
        chk_cnt("R4", 1, 0, 3);
        chk_ctx("R4 keep", 16'h0000, 16'h0000, 16'h0000);
    endtask

    task automatic t_return_first();
        mem[ix(16'h001A)] = 16'h0200;
        mem[ix(16'h001C)] = 16'h1000;
        mem[ix(16'h001E)] = 16'hBEEF;
        run_cmd(2'd3, 4'd0, 16'h0, 16'h0);
        chk_ctx("R8 return", 16'h0200, 16'h1000, 16'hBEEF);
        chk_cnt("R8 R10 return", 3, 0, 5);
    endtask

    task automatic t_nested();
        mem[ix(16'h0300)] = 16'h0400; mem[ix(16'h0302)] = 16'h2000;
        mem[ix(16'h0310)] = 16'h0500; mem[ix(16'h0312)] = 16'h3000;
        run_cmd(2'd2, 4'd0, 16'h0, 16'h0300);
        chk_ctx("R5 switch", 16'h0400, 16'h2000, 16'hBEEF);
        chk_cnt("R10 R7 switch", 2, 3, 6);
        chk("R6 save wp", mem[ix(16'h041A)], 16'h0200);
        chk("R6 save pc", mem[ix(16'h041C)], 16'h1000);
        chk("R6 save st", mem[ix(16'h041E)], 16'hBEEF);
        run_cmd(2'd2, 4'd0, 16'h0, 16'h0310);
        chk_ctx("R9 nested switch", 16'h0500, 16'h3000, 16'hBEEF);
        chk("R9 link", mem[ix(16'h051A)], 16'h0400);
        run_cmd(2'd3, 4'd0, 16'h0, 16'h0);
        chk_ctx("R9 unwind 1", 16'h0400, 16'h2000, 16'hBEEF);
        run_cmd(2'd3, 4'd0, 16'h0, 16'h0);
        chk_ctx("R9 unwind 2", 16'h0200, 16'h1000, 16'hBEEF);
    endtask

    task automatic t_overlap();
        mem[ix(16'h0618)] = 16'h0600;
        mem[ix(16'h061A)] = 16'h5000;
        run_cmd(2'd2, 4'd0, 16'h0, 16'h0618);
        chk_ctx("R7 overlap", 16'h0600, 16'h5000, 16'hBEEF);
        chk("R7 overlap link", mem[ix(16'h061A)], 16'h0200);
        chk("R7 order", 16'(n_order), 16'd0);
    endtask

    task automatic t_wrap();
        mem[ix(16'h0320)] = 16'hFFF0;
        mem[ix(16'h0322)] = 16'h6000;
        run_cmd(2'd2, 4'd0, 16'h0, 16'h0320);
        chk_ctx("R5 wrap switch", 16'hFFF0, 16'h6000, 16'hBEEF);
        chk("R2 R6 wrap save wp", mem[ix(16'h000A)], 16'h0600);
        chk("R2 R6 wrap save pc", mem[ix(16'h000C)], 16'h5000);
        chk("R2 R6 wrap save st", mem[ix(16'h000E)], 16'hBEEF);
        run_cmd(2'd1, 4'd8, 16'h7777, 16'h0);
        chk("R2 wrap write", mem[ix(16'h0000)], 16'h7777);
    endtask

    task automatic t_busy_ignore();
        mem[ix(16'h0600)] = 16'h1111;
        mem[ix(16'hFFF0)] = 16'h2222;
        @(negedge clk);
        s_rd = n_rd; s_wr = n_wr; s_busy = n_busy;
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_op = 2'd1; cmd_reg = 4'd0; cmd_wdata = 16'hDEAD;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk_ctx("R11 return result", 16'h0600, 16'h5000, 16'hBEEF);
        chk_cnt("R11 ignored", 3, 0, 5);
        chk("R11 mem new ws", mem[ix(16'h0600)], 16'h1111);
        chk("R11 mem old ws", mem[ix(16'hFFF0)], 16'h2222);
        chk("R2 odd addresses", 16'(n_odd), 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_return_first();
        t_nested();
        t_overlap();
        t_wrap();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule